// File: doc/BRIEF.md
# Fuse Array Register Controller

This block sits on a simple 32-bit register bus and fronts a small one-time-programmable fuse array of 32-bit words. Software sets up a bank of control registers that model the pins of a fuse macro. These include the word address, chip enable, read strobe, trim enable, clock, data in, program, write enable and several test controls. Software then reads the selected fuse word through a read-only data-out register. Every control register other than data-out returns the value last written to it.

The fuse word only reaches the bus when the chip-enable, strobe and trim enable bits (bit 0 of each) are all set. In every other case data-out reads as zero. After reset an initialisation sweep fills the array with all-ones, one word per cycle. The sweep places a serial-number word at a fixed index and its bitwise complement in the next word. Data-out reads as zero until the sweep is done.

Only full 32-bit accesses to the defined, word-aligned offsets are accepted. Any other access raises an error strobe, and that access has no effect on the registers.

Top module: `fuse_ctrl_top`

## Requirements
- R1: After reset every control register reads back as zero.
- R2: Every control register except data-out (offset 0x18) returns the value last written to it. The offsets are 0x00 address, 0x04 IO control, 0x08 array select, 0x0C chip enable, 0x10 clock, 0x14 data in, 0x1C strobe, 0x20 program, 0x24 test control, 0x28 test mode, 0x2C test repeat, 0x30 test retention, 0x34 trim and 0x38 write enable.
- R3: A write to the address register keeps only its low ADDR_BITS bits (10 by default), and the other bits read back as zero.
- R4: A read of data-out returns the fuse word at the address register when bit 0 of chip enable, bit 0 of strobe and bit 0 of trim are all set.
- R5: When any one of those three enable bits is clear, a read of data-out returns zero.
- R6: Once initialisation is done, every fuse word holds 0xFFFFFFFF, except two. Word SERIAL_IDX (0xFC) holds SERIAL and word SERIAL_IDX+1 holds ~SERIAL.
- R7: For FUSE_WORDS cycles after reset, while the initialisation sweep runs, data-out reads as zero.
- R8: An access whose byte enables are not all four set (4'hF) raises bus_err in the response cycle. If it is a read it returns zero. If it is a write it changes no register.
- R9: An access to a misaligned offset or to an offset above 0x38 raises bus_err in the response cycle. If it is a read it returns zero. If it is a write it changes no register.
- R10: A write to data-out is ignored and raises no error: the fuse word read afterwards is unchanged.
- R11: Every read request produces rd_valid exactly one cycle later, and a write produces no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | BUS_ADDR_W (8) | Byte offset of the register |
| be | input | 4 | Byte enables, only 4'hF is accepted |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe, one cycle after the request |
| rd_data | output | 32 | Read response data |
| bus_err | output | 1 | Rejected access, one cycle after the request |

## Verification
The bench goes after the enable gate with every combination of the three enable bits. A design that tested the wrong bit, or that tested only one enable, would leak fuse data with one enable clear. The bench reads the serial word, its complement and their neighbours. An off-by-one placement or a missing complement would show up there as a wrong word. Reads during the initialisation sweep would expose stale array content. The bench also writes wide values to the address register; an unmasked address would read back its high bits. Finally, partial byte enables, misaligned offsets, offsets past the end and writes to data-out are each followed by a read-back. A design that let any of them through would show a changed register or fuse word.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int NREG = 15;

  typedef enum logic [3:0] {
    R_ADDR    = 4'd0,
    R_IOCTL   = 4'd1,
    R_ASEL    = 4'd2,
    R_CHIPEN  = 4'd3,
    R_CLK     = 4'd4,
    R_DATAIN  = 4'd5,
    R_DATAOUT = 4'd6,
    R_STROBE  = 4'd7,
    R_PROG    = 4'd8,
    R_TCTL    = 4'd9,
    R_TMODE   = 4'd10,
    R_TREP    = 4'd11,
    R_TRET    = 4'd12,
    R_TRIM    = 4'd13,
    R_WREN    = 4'd14
  } reg_idx_e;
endpackage

// File: rtl/fuse_regfile.sv
module fuse_regfile
  import fuse_pkg::*;
#(
  parameter int BUS_ADDR_W = 8,
  parameter int ADDR_BITS  = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  we,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [3:0]            be,
  input  logic [31:0]           wdata,
  output logic [31:0]           reg_rdata_q,
  output logic                  rd_valid_q,
  output logic                  err_q,
  output logic                  dout_sel_q,
  output logic [ADDR_BITS-1:0]  fuse_addr,
  output logic                  en_all
);
  localparam int IDX_W = BUS_ADDR_W - 2;
  localparam logic [31:0] ADDR_MASK = (32'd1 << ADDR_BITS) - 32'd1;

  logic [31:0]      regs [NREG];
  logic [IDX_W-1:0] idx;
  logic             acc_ok;
  logic [3:0]       ridx;

  assign idx    = addr[BUS_ADDR_W-1:2];
  assign acc_ok = (be == 4'hF) && (addr[1:0] == 2'b00) && (32'(idx) < 32'(NREG));
  assign ridx   = idx[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      reg_rdata_q <= '0;
      rd_valid_q  <= 1'b0;
      err_q       <= 1'b0;
      dout_sel_q  <= 1'b0;
    end else begin
      rd_valid_q <= req && !we;
      err_q      <= req && !acc_ok;
      dout_sel_q <= req && !we && acc_ok && (ridx == R_DATAOUT);
      reg_rdata_q <= '0;
      if (req && acc_ok) begin
        if (we) begin
          if (ridx == R_ADDR)
            regs[ridx] <= wdata & ADDR_MASK;
          else if (ridx != R_DATAOUT)
            regs[ridx] <= wdata;
        end else if (ridx != R_DATAOUT) begin
          reg_rdata_q <= regs[ridx];
        end
      end
    end
  end

  assign fuse_addr = regs[R_ADDR][ADDR_BITS-1:0];
  assign en_all    = regs[R_CHIPEN][0] && regs[R_STROBE][0] && regs[R_TRIM][0];
endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int          FUSE_WORDS = 1024,
  parameter int          ADDR_BITS  = 10,
  parameter int          SERIAL_IDX = 252,
  parameter logic [31:0] SERIAL     = 32'h0000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [31:0]          rd_word_q,
  output logic                 init_done
);
  localparam int CNT_W = ADDR_BITS + 1;

  logic [31:0]      mem [FUSE_WORDS];
  logic [CNT_W-1:0] sweep_cnt;
  logic [31:0]      init_word;

  always_comb begin
    if (32'(sweep_cnt) == 32'(SERIAL_IDX))
      init_word = SERIAL;
    else if (32'(sweep_cnt) == 32'(SERIAL_IDX + 1))
      init_word = ~SERIAL;
    else
      init_word = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_cnt <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (32'(sweep_cnt) == 32'(FUSE_WORDS - 1)) init_done <= 1'b1;
      sweep_cnt <= sweep_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !init_done) mem[sweep_cnt[ADDR_BITS-1:0]] <= init_word;
    rd_word_q <= mem[rd_addr];
  end
endmodule

// File: rtl/fuse_ctrl_top.sv
module fuse_ctrl_top #(
  parameter int          BUS_ADDR_W = 8,
  parameter int          FUSE_WORDS = 1024,
  parameter int          ADDR_BITS  = 10,
  parameter int          SERIAL_IDX = 252,
  parameter logic [31:0] SERIAL     = 32'h1234_ABCD
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  we,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [3:0]            be,
  input  logic [31:0]           wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic                  bus_err
);
  logic [31:0]          reg_rdata_q;
  logic                 dout_sel_q;
  logic [ADDR_BITS-1:0] fuse_addr;
  logic                 en_all;
  logic [31:0]          fuse_word_q;
  logic                 init_done;
  logic                 gate_q;

  fuse_regfile #(.BUS_ADDR_W(BUS_ADDR_W), .ADDR_BITS(ADDR_BITS)) u_regs (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .reg_rdata_q(reg_rdata_q), .rd_valid_q(rd_valid),
    .err_q(bus_err), .dout_sel_q(dout_sel_q), .fuse_addr(fuse_addr),
    .en_all(en_all)
  );

  fuse_array #(.FUSE_WORDS(FUSE_WORDS), .ADDR_BITS(ADDR_BITS),
               .SERIAL_IDX(SERIAL_IDX), .SERIAL(SERIAL)) u_array (
    .clk(clk), .rst(rst), .rd_addr(fuse_addr), .rd_word_q(fuse_word_q),
    .init_done(init_done)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= en_all && init_done;
  end

  always_comb begin
    if (!rd_valid)       rd_data = '0;
    else if (dout_sel_q) rd_data = gate_q ? fuse_word_q : '0;
    else                 rd_data = reg_rdata_q;
  end
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
  parameter int BUS_ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req,
  input logic                  we,
  input logic [BUS_ADDR_W-1:0] addr,
  input logic [3:0]            be,
  input logic                  rd_valid,
  input logic [31:0]           rd_data,
  input logic                  bus_err,
  input logic                  en_all
);
  AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rd_valid); // R11
  AST_NO_RDV_ELSE: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> !rd_valid); // R11
  AST_PARTIAL_BE_ERR: assert property (@(posedge clk) disable iff (rst)
    (req && be != 4'hF) |=> bus_err); // R8
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && bus_err) |-> (rd_data == 32'd0)); // R9
  AST_GATE_CLOSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req && !we && be == 4'hF && addr == BUS_ADDR_W'(8'h18) && !en_all)
      |=> (rd_data == 32'd0)); // R5
endmodule

bind fuse_ctrl_top fuse_ctrl_chk #(.BUS_ADDR_W(BUS_ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
  .rd_valid(rd_valid), .rd_data(rd_data), .bus_err(bus_err), .en_all(en_all)
);

// File: tb/tb_fuse_ctrl_top.sv
module tb_fuse_ctrl_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          WORDS      = 1024;
  localparam int          SER_IDX    = 252;
  localparam logic [31:0] SER        = 32'h1234_ABCD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        bus_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] shadow [15];

  fuse_ctrl_top dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data), .bus_err(bus_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] fuse_exp(input int i);
    if (i == SER_IDX) return SER;
    if (i == SER_IDX + 1) return ~SER;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] wr_exp(input int r, input logic [31:0] d);
    if (r == 0) return d & 32'h0000_03FF;
    return d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [3:0] b,
                        input logic [31:0] d, output logic v, output logic [31:0] q,
                        output logic e);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    v = rd_valid; q = rd_data; e = bus_err;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic v, e; logic [31:0] q;
    access(1'b1, a, 4'hF, d, v, q, e);
    check("R11 no rd_valid on write", {31'd0, v}, 32'd0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    logic v, e;
    access(1'b0, a, 4'hF, 32'd0, v, q, e);
    check("R11 rd_valid on read", {31'd0, v}, 32'd1);
  endtask

  task automatic set_enables(input logic ce, input logic st, input logic tr);
    wr(8'h0C, {31'd0, ce}); wr(8'h1C, {31'd0, st}); wr(8'h34, {31'd0, tr});
    shadow[3] = {31'd0, ce}; shadow[7] = {31'd0, st}; shadow[13] = {31'd0, tr};
  endtask

  initial begin
    logic [31:0] q;
    logic v, e;
    void'($urandom(32'd7391));
    for (int i = 0; i < 15; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: fuse reads blocked while the sweep runs
    wr(8'h00, 32'd5);
    set_enables(1'b1, 1'b1, 1'b1);
    rd(8'h18, q); check("R7 dout during init", q, 32'd0);

    repeat (WORDS + 10) @(negedge clk);

    // R1: reset values (enable regs were written, others still zero)
    for (int r = 0; r < 15; r++) begin
      if (r != 0 && r != 3 && r != 7 && r != 13 && r != 6) begin
        rd(8'(r * 4), q); check("R1 reset value", q, 32'd0);
      end
    end

    // R6 / R4: serial pair and neighbours
    for (int i = SER_IDX - 1; i <= SER_IDX + 2; i++) begin
      wr(8'h00, 32'(i)); rd(8'h18, q); check("R6 fuse content", q, fuse_exp(i));
    end
    wr(8'h00, 32'd0);   rd(8'h18, q); check("R6 word 0", q, 32'hFFFF_FFFF);
    wr(8'h00, 32'd1023); rd(8'h18, q); check("R4 last word", q, 32'hFFFF_FFFF);

    // R3: address masking
    wr(8'h00, 32'hABCD_F0FC); rd(8'h00, q); check("R3 addr mask", q, 32'h0000_00FC);
    rd(8'h18, q); check("R4 masked addr selects serial", q, SER);

    // R5: every enable combination
    for (int m = 0; m < 8; m++) begin
      set_enables(m[0], m[1], m[2]);
      rd(8'h18, q);
      check(m == 7 ? "R4 gate open" : "R5 gate closed", q, (m == 7) ? SER : 32'd0);
    end
    // upper bits of enables do not count, only bit 0
    wr(8'h0C, 32'hFFFF_FFFE); rd(8'h18, q); check("R5 ce bit0 clear", q, 32'd0);
    set_enables(1'b1, 1'b1, 1'b1);

    // R10: write to data-out ignored
    access(1'b1, 8'h18, 4'hF, 32'h0, v, q, e);
    check("R10 no error on dout write", {31'd0, e}, 32'd0);
    rd(8'h18, q); check("R10 fuse unchanged", q, SER);

    // R8: partial byte enables
    access(1'b1, 8'h14, 4'h3, 32'hDEAD_BEEF, v, q, e);
    check("R8 err partial write", {31'd0, e}, 32'd1);
    rd(8'h14, q); check("R8 write ignored", q, shadow[5]);
    access(1'b0, 8'h14, 4'h1, 32'h0, v, q, e);
    check("R8 err partial read", {31'd0, e}, 32'd1);
    check("R8 partial read zero", q, 32'd0);

    // R9: bad offsets
    access(1'b1, 8'h3C, 4'hF, 32'h5555_5555, v, q, e);
    check("R9 err past end", {31'd0, e}, 32'd1);
    access(1'b0, 8'hFC, 4'hF, 32'h0, v, q, e);
    check("R9 err far read", {31'd0, e}, 32'd1);
    check("R9 bad read zero", q, 32'd0);
    check("R11 rd_valid on bad read", {31'd0, v}, 32'd1);
    access(1'b1, 8'h21, 4'hF, 32'h7777_7777, v, q, e);
    check("R9 err misaligned", {31'd0, e}, 32'd1);
    rd(8'h20, q); check("R9 misaligned write ignored", q, shadow[8]);

    // R2: random writes and readbacks
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [31:0] d;
      r = int'($urandom_range(14, 0));
      d = $urandom;
      if (r == 6) continue;
      if (r == 3 || r == 7 || r == 13) d[0] = 1'b1;
      wr(8'(r * 4), d);
      shadow[r] = wr_exp(r, d);
      r = int'($urandom_range(14, 0));
      if (r == 6) begin
        rd(8'h18, q); check("R4 random fuse read", q, fuse_exp(int'(shadow[0][9:0])));
      end else begin
        rd(8'(r * 4), q); check("R2 readback", q, shadow[r]);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule